// File: doc/BRIEF.md
# Serial Line Bus Register Interface

This block is the bus-slave front end of one asynchronous serial line. It answers a relocatable window of four 16-bit word registers: one status and one data register for receive, and one status and one data register for transmit. The window sits in the top I/O page of an 18-bit address space. Static strap inputs set where it sits and which pair of interrupt vectors it presents. The address straps are active for a zero bit and the vector straps are active for a one bit, so the two strap groups have opposite polarity.

On the line side it exchanges single bytes with a serial shifter core through a valid/ready style handshake. On the interrupt side it raises separate receive and transmit requests. A small arbiter picks one request, receive first, and holds its vector until the bus acknowledges. The transmit vector is always the receive vector plus 4.

Top module: `sl_bus_regs`

## Requirements
- R1: The window base is byte address {bits 17..11 all ones, bits 10..3 equal to the inverted address straps (strap bit i drives address bit i+3), bits 2..0 zero}. An access hits when bus address bits 17..3 equal the base. The bus carries byte address bits 17..1 only.
- R2: Byte address bits 2..1 select the word: 0 is receive status, 1 is receive data, 2 is transmit status, 3 is transmit data.
- R3: An access outside the window gets no acknowledge, returns zero data and changes no state.
- R4: An access that hits raises bus_ack_o for exactly the next cycle, with its read data on bus_rdata_o in that same cycle. bus_rdata_o is zero whenever bus_ack_o is low and on write acknowledges.
- R5: In both status words, bit 7 is a flag that the bus cannot write and bit 6 is a read/write interrupt enable. All other status bits read as zero. The receive data word returns the byte in bits 7..0. The transmit data word reads as zero.
- R6: A cycle with rx_valid_i stores rx_byte_i and sets the receive done flag. A read of the receive data word clears the flag unless rx_valid_i arrives in the same cycle, in which case the flag stays set.
- R7: A write to the transmit data word while the transmit ready flag is set places bits 7..0 on tx_byte_o, raises tx_valid_o and clears ready. tx_valid_o and tx_byte_o then hold, and further data writes are ignored, until a cycle with tx_ready_i sets ready again.
- R8: irq_rx_o equals receive done AND receive enable. irq_tx_o equals transmit ready AND transmit enable.
- R9: The receive vector is {vector straps in bits 8..3, 000}. The transmit vector is the receive vector with bit 2 set (base+4).
- R10: When no vector is held and a request is pending, the next cycle raises vec_valid_o with the receive vector if irq_rx_o was set, otherwise with the transmit vector. vec_valid_o and vec_o hold until a cycle with irq_ack_i, after which vec_valid_o is low for one cycle. vec_o is zero while vec_valid_o is low.
- R11: After reset, both enables and the receive done flag are zero, transmit ready is one, and bus_ack_o, tx_valid_o and vec_valid_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_strap_i | input | 8 | Address straps; asserted bit sets address bit i+3 to zero |
| vec_strap_i | input | 6 | Vector straps; asserted bit sets vector bit i+3 to one |
| bus_req_i | input | 1 | Bus access request, one cycle per access |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | 17 | Byte address bits 17..1 |
| bus_wdata_i | input | 16 | Write data |
| bus_ack_o | output | 1 | Access acknowledge, one cycle after a hit |
| bus_rdata_o | output | 16 | Read data, valid with bus_ack_o |
| rx_valid_i | input | 1 | Receiver core delivers a byte |
| rx_byte_i | input | 8 | Received byte |
| tx_valid_o | output | 1 | Byte offered to the transmitter core |
| tx_byte_o | output | 8 | Byte to transmit |
| tx_ready_i | input | 1 | Transmitter core takes the offered byte |
| irq_rx_o | output | 1 | Receive interrupt request |
| irq_tx_o | output | 1 | Transmit interrupt request |
| irq_ack_i | input | 1 | Interrupt acknowledge, releases the held vector |
| vec_valid_o | output | 1 | A vector is presented |
| vec_o | output | 9 | Presented interrupt vector |

## Verification
The decoder is tried with random address strap values, each probed at its computed window and at random addresses that are forced to miss. This separates a polarity or bit-order error in the straps from an error in the fixed upper bits. Two directed strap settings place the window at octal 777560 and octal 776500, which pins the absolute bit positions. Random received bytes go through a store, read and flag-clear round trip. Directed sequences cover writes to read-only flags, a second transmit write while the core is busy, and both interrupts pending at once. The last case shows that receive wins the arbitration, that the vector holds across a flag change, and that transmit gets base+4 after release.

// File: rtl/sl_bus_pkg.sv
package sl_bus_pkg;
  typedef enum logic [1:0] {
    SEL_RXCS  = 2'd0,
    SEL_RXBUF = 2'd1,
    SEL_TXCS  = 2'd2,
    SEL_TXBUF = 2'd3
  } reg_sel_e;

  typedef enum logic {
    SRC_RX = 1'b0,
    SRC_TX = 1'b1
  } irq_src_e;

  localparam int FLAG_BIT = 7;
  localparam int IE_BIT   = 6;
  localparam int BLK_LSB  = 3;  // 8-byte window
endpackage

// File: rtl/sl_addr_decode.sv
module sl_addr_decode
  import sl_bus_pkg::*;
#(
  parameter int AW       = 18,
  parameter int ASTRAP_W = 8
) (
  input  logic [AW-1:1]       addr_i,
  input  logic [ASTRAP_W-1:0] strap_i,
  output logic                hit_o,
  output reg_sel_e            sel_o
);
  localparam int FIX_LO = BLK_LSB + ASTRAP_W;

  logic [AW-1:BLK_LSB] base_blk;

  // strap asserted -> address bit is zero
  for (genvar i = 0; i < ASTRAP_W; i++) begin : g_astrap
    assign base_blk[BLK_LSB+i] = ~strap_i[i];
  end

  // I/O page: all bits above the strapped field are ones
  for (genvar j = FIX_LO; j < AW; j++) begin : g_fixed
    assign base_blk[j] = 1'b1;
  end

  assign hit_o = (addr_i[AW-1:BLK_LSB] == base_blk);
  assign sel_o = reg_sel_e'(addr_i[2:1]);
endmodule

// File: rtl/sl_rx_chan.sv
module sl_rx_chan #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_we_i,
  input  logic          ie_d_i,
  input  logic          buf_rd_i,
  input  logic          rx_valid_i,
  input  logic [CW-1:0] rx_byte_i,
  output logic          done_o,
  output logic          ie_o,
  output logic [CW-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      ie_o   <= 1'b0;
      data_o <= '0;
    end else begin
      if (cs_we_i) ie_o <= ie_d_i;
      // new byte wins over a same-cycle buffer read
      if (rx_valid_i) begin
        data_o <= rx_byte_i;
        done_o <= 1'b1;
      end else if (buf_rd_i) begin
        done_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sl_tx_chan.sv
module sl_tx_chan #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_we_i,
  input  logic          ie_d_i,
  input  logic          buf_we_i,
  input  logic [CW-1:0] wbyte_i,
  input  logic          tx_ready_i,
  output logic          ready_o,
  output logic          ie_o,
  output logic          tx_valid_o,
  output logic [CW-1:0] tx_byte_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_o   <= 1'b1;
      ie_o      <= 1'b0;
      tx_byte_o <= '0;
    end else begin
      if (cs_we_i) ie_o <= ie_d_i;
      if (ready_o) begin
        if (buf_we_i) begin
          tx_byte_o <= wbyte_i;
          ready_o   <= 1'b0;
        end
      end else if (tx_ready_i) begin
        ready_o <= 1'b1;
      end
    end
  end

  assign tx_valid_o = ~ready_o;
endmodule

// File: rtl/sl_irq_arb.sv
module sl_irq_arb
  import sl_bus_pkg::*;
#(
  parameter int VSTRAP_W = 6
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_rx_i,
  input  logic                  req_tx_i,
  input  logic                  ack_i,
  input  logic [VSTRAP_W-1:0]   strap_i,
  output logic                  vec_valid_o,
  output logic [VSTRAP_W+2:0]   vec_o
);
  irq_src_e src_q;
  logic     grant_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_q <= 1'b0;
      src_q   <= SRC_RX;
    end else if (grant_q) begin
      if (ack_i) grant_q <= 1'b0;
    end else if (req_rx_i || req_tx_i) begin
      grant_q <= 1'b1;
      src_q   <= req_rx_i ? SRC_RX : SRC_TX;
    end
  end

  assign vec_valid_o = grant_q;
  // strap asserted -> vector bit is one; tx sits at base+4
  assign vec_o = grant_q ? {strap_i, (src_q == SRC_TX), 2'b00} : '0;
endmodule

// File: rtl/sl_bus_regs.sv
module sl_bus_regs
  import sl_bus_pkg::*;
#(
  parameter int AW       = 18,
  parameter int DW       = 16,
  parameter int CW       = 8,
  parameter int ASTRAP_W = 8,
  parameter int VSTRAP_W = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ASTRAP_W-1:0]  addr_strap_i,
  input  logic [VSTRAP_W-1:0]  vec_strap_i,
  input  logic                 bus_req_i,
  input  logic                 bus_we_i,
  input  logic [AW-1:1]        bus_addr_i,
  input  logic [DW-1:0]        bus_wdata_i,
  output logic                 bus_ack_o,
  output logic [DW-1:0]        bus_rdata_o,
  input  logic                 rx_valid_i,
  input  logic [CW-1:0]        rx_byte_i,
  output logic                 tx_valid_o,
  output logic [CW-1:0]        tx_byte_o,
  input  logic                 tx_ready_i,
  output logic                 irq_rx_o,
  output logic                 irq_tx_o,
  input  logic                 irq_ack_i,
  output logic                 vec_valid_o,
  output logic [VSTRAP_W+2:0]  vec_o
);
  logic     hit;
  reg_sel_e sel;
  logic     acc, acc_wr, acc_rd;
  logic     rx_done, rx_ie, tx_ready, tx_ie;
  logic [CW-1:0] rx_data;
  logic [DW-1:0] rd_mux;
  logic     unused_wdata;

  assign unused_wdata = ^bus_wdata_i[DW-1:CW];

  sl_addr_decode #(.AW(AW), .ASTRAP_W(ASTRAP_W)) u_dec (
    .addr_i (bus_addr_i),
    .strap_i(addr_strap_i),
    .hit_o  (hit),
    .sel_o  (sel)
  );

  assign acc    = bus_req_i & hit;
  assign acc_wr = acc & bus_we_i;
  assign acc_rd = acc & ~bus_we_i;

  sl_rx_chan #(.CW(CW)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_we_i   (acc_wr && sel == SEL_RXCS),
    .ie_d_i    (bus_wdata_i[IE_BIT]),
    .buf_rd_i  (acc_rd && sel == SEL_RXBUF),
    .rx_valid_i(rx_valid_i),
    .rx_byte_i (rx_byte_i),
    .done_o    (rx_done),
    .ie_o      (rx_ie),
    .data_o    (rx_data)
  );

  sl_tx_chan #(.CW(CW)) u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_we_i   (acc_wr && sel == SEL_TXCS),
    .ie_d_i    (bus_wdata_i[IE_BIT]),
    .buf_we_i  (acc_wr && sel == SEL_TXBUF),
    .wbyte_i   (bus_wdata_i[CW-1:0]),
    .tx_ready_i(tx_ready_i),
    .ready_o   (tx_ready),
    .ie_o      (tx_ie),
    .tx_valid_o(tx_valid_o),
    .tx_byte_o (tx_byte_o)
  );

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_RXCS: begin
        rd_mux[FLAG_BIT] = rx_done;
        rd_mux[IE_BIT]   = rx_ie;
      end
      SEL_RXBUF: rd_mux[CW-1:0] = rx_data;
      SEL_TXCS: begin
        rd_mux[FLAG_BIT] = tx_ready;
        rd_mux[IE_BIT]   = tx_ie;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_ack_o   <= 1'b0;
      bus_rdata_o <= '0;
    end else begin
      bus_ack_o   <= acc;
      bus_rdata_o <= acc_rd ? rd_mux : '0;
    end
  end

  assign irq_rx_o = rx_done & rx_ie;
  assign irq_tx_o = tx_ready & tx_ie;

  sl_irq_arb #(.VSTRAP_W(VSTRAP_W)) u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_rx_i   (irq_rx_o),
    .req_tx_i   (irq_tx_o),
    .ack_i      (irq_ack_i),
    .strap_i    (vec_strap_i),
    .vec_valid_o(vec_valid_o),
    .vec_o      (vec_o)
  );
endmodule

// File: rtl/sl_bus_regs_chk.sv
module sl_bus_regs_chk #(
  parameter int AW       = 18,
  parameter int DW       = 16,
  parameter int CW       = 8,
  parameter int ASTRAP_W = 8,
  parameter int VSTRAP_W = 6
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [ASTRAP_W-1:0] addr_strap_i,
  input logic [VSTRAP_W-1:0] vec_strap_i,
  input logic                bus_req_i,
  input logic                bus_we_i,
  input logic [AW-1:1]       bus_addr_i,
  input logic                bus_ack_o,
  input logic [DW-1:0]       bus_rdata_o,
  input logic                rx_valid_i,
  input logic                tx_valid_o,
  input logic [CW-1:0]       tx_byte_o,
  input logic                tx_ready_i,
  input logic                irq_rx_o,
  input logic                irq_ack_i,
  input logic                vec_valid_o,
  input logic [VSTRAP_W+2:0] vec_o
);
  localparam int HI_W = AW - 3 - ASTRAP_W;

  logic win;
  assign win = (bus_addr_i[AW-1:3] == {{HI_W{1'b1}}, ~addr_strap_i});

  p_ack_hit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_i && win |=> bus_ack_o);

  p_no_ack_miss_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_i && !win |=> !bus_ack_o);

  p_rdata_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_ack_o |-> bus_rdata_o == '0);

  p_rx_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_i && !bus_we_i && win && bus_addr_i[2:1] == 2'd1 && !rx_valid_i
    |=> !irq_rx_o);

  p_tx_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_byte_o));

  p_tx_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && tx_ready_i |=> !tx_valid_o);

  p_vec_pair_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> vec_o[VSTRAP_W+2:3] == vec_strap_i && vec_o[1:0] == 2'b00);

  p_vec_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o && !irq_ack_i |=> vec_valid_o && $stable(vec_o));

  p_rx_first_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vec_valid_o && irq_rx_o |=> vec_valid_o && vec_o[2] == 1'b0);

  p_vec_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vec_valid_o |-> vec_o == '0);
endmodule

bind sl_bus_regs sl_bus_regs_chk #(
  .AW(AW), .DW(DW), .CW(CW), .ASTRAP_W(ASTRAP_W), .VSTRAP_W(VSTRAP_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_strap_i(addr_strap_i),
  .vec_strap_i (vec_strap_i),
  .bus_req_i   (bus_req_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_ack_o   (bus_ack_o),
  .bus_rdata_o (bus_rdata_o),
  .rx_valid_i  (rx_valid_i),
  .tx_valid_o  (tx_valid_o),
  .tx_byte_o   (tx_byte_o),
  .tx_ready_i  (tx_ready_i),
  .irq_rx_o    (irq_rx_o),
  .irq_ack_i   (irq_ack_i),
  .vec_valid_o (vec_valid_o),
  .vec_o       (vec_o)
);

// File: tb/sl_bus_regs_tb.sv
module sl_bus_regs_tb;
  localparam int AW = 18, DW = 16, CW = 8, ASW = 8, VSW = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [ASW-1:0] addr_strap = '0;
  logic [VSW-1:0] vec_strap = 6'b011000;
  logic bus_req = 1'b0, bus_we = 1'b0;
  logic [AW-1:1] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic bus_ack;
  logic [DW-1:0] bus_rdata;
  logic rx_valid = 1'b0;
  logic [CW-1:0] rx_byte = '0;
  logic tx_valid;
  logic [CW-1:0] tx_byte;
  logic tx_ready = 1'b0;
  logic irq_rx, irq_tx, irq_ack = 1'b0, vec_valid;
  logic [VSW+2:0] vec;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sl_bus_regs #(.AW(AW), .DW(DW), .CW(CW), .ASTRAP_W(ASW), .VSTRAP_W(VSW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_strap_i(addr_strap), .vec_strap_i(vec_strap),
    .bus_req_i(bus_req), .bus_we_i(bus_we), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
    .bus_ack_o(bus_ack), .bus_rdata_o(bus_rdata), .rx_valid_i(rx_valid), .rx_byte_i(rx_byte),
    .tx_valid_o(tx_valid), .tx_byte_o(tx_byte), .tx_ready_i(tx_ready),
    .irq_rx_o(irq_rx), .irq_tx_o(irq_tx), .irq_ack_i(irq_ack),
    .vec_valid_o(vec_valid), .vec_o(vec)
  );

  function automatic logic [AW-1:0] exp_base(input logic [ASW-1:0] s);
    return {7'h7F, ~s, 3'b000};
  endfunction

  function automatic logic [VSW+2:0] exp_vec(input logic [VSW-1:0] s, input bit tx);
    return {s, tx, 2'b00};
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic ack, output logic [DW-1:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a[AW-1:1];
    @(negedge clk);
    ack = bus_ack; d = bus_rdata;
    bus_req = 1'b0;
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] v, output logic ack);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a[AW-1:1]; bus_wdata = v;
    @(negedge clk);
    ack = bus_ack;
    chk("R4 write rdata", {16'h0, bus_rdata}, 32'h0);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic pulse_rx(input logic [CW-1:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [DW-1:0] d;
    logic [AW-1:0] base, a;
    logic [CW-1:0] b;
    int unsigned seed;
    seed = $urandom(32'h5eed);

    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11 ack", {31'h0, bus_ack}, 0);
    chk("R11 tx_valid", {31'h0, tx_valid}, 0);
    chk("R11 vec_valid", {31'h0, vec_valid}, 0);
    chk("R11 irq", {30'h0, irq_rx, irq_tx}, 0);
    base = exp_base(addr_strap);
    bus_rd(base, ack, d);
    chk("R11 rx status", {15'h0, ack, d}, {15'h0, 1'b1, 16'h0000});
    bus_rd(base + 4, ack, d);
    chk("R11 tx status", {15'h0, ack, d}, {15'h0, 1'b1, 16'h0080});

    // R1 R2 R3 random strap windows and misses
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      addr_strap = ASW'($urandom);
      base = exp_base(addr_strap);
      bus_rd(base + 4, ack, d);
      chk("R1 R2 tx status at window", {15'h0, ack, d}, {15'h0, 1'b1, 16'h0080});
      bus_rd(base + 6, ack, d);
      chk("R2 tx data reads zero", {15'h0, ack, d}, {15'h0, 1'b1, 16'h0000});
      a = AW'($urandom);
      if (a[AW-1:3] == base[AW-1:3]) a[3] = ~a[3];
      bus_rd(a, ack, d);
      chk("R3 miss read", {15'h0, ack, d}, 32'h0);
    end

    // R1 directed strap settings
    @(negedge clk); addr_strap = 8'h11;
    chk("R1 console base", {14'h0, exp_base(addr_strap)}, {14'h0, 18'o777560});
    bus_rd(18'o777564, ack, d);
    chk("R1 console tx status", {15'h0, ack, d}, {15'h0, 1'b1, 16'h0080});
    @(negedge clk); addr_strap = 8'h57;
    bus_rd(18'o776504, ack, d);
    chk("R1 second line tx status", {15'h0, ack, d}, {15'h0, 1'b1, 16'h0080});
    bus_rd(18'o777564, ack, d);
    chk("R3 old window misses", {15'h0, ack, d}, 32'h0);
    base = 18'o776500;

    // R5 status write masks
    bus_wr(base, 16'hFFFF, ack);
    chk("R5 rx status write ack", {31'h0, ack}, 1);
    bus_rd(base, ack, d);
    chk("R5 rx status only ie", {16'h0, d}, 32'h0040);
    bus_wr(base, 16'h0080, ack);
    bus_rd(base, ack, d);
    chk("R5 flag not writable", {16'h0, d}, 32'h0000);
    bus_wr(base + 2, 16'h00FF, ack);
    bus_rd(base, ack, d);
    chk("R5 rx data write no effect", {16'h0, d}, 32'h0000);

    // R6 receive round trips
    for (int i = 0; i < 8; i++) begin
      b = CW'($urandom);
      pulse_rx(b);
      bus_rd(base, ack, d);
      chk("R6 done set", {16'h0, d}, 32'h0080);
      bus_rd(base + 2, ack, d);
      chk("R6 rx data", {15'h0, ack, d}, {15'h0, 1'b1, 8'h00, b});
      bus_rd(base, ack, d);
      chk("R6 done cleared", {16'h0, d}, 32'h0000);
    end

    // R6 read and new byte in same cycle
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = base[AW-1:1] + 17'd1;
    rx_valid = 1'b1; rx_byte = 8'h3C;
    @(negedge clk);
    bus_req = 1'b0; rx_valid = 1'b0;
    bus_rd(base, ack, d);
    chk("R6 new byte wins", {16'h0, d}, 32'h0080);
    bus_rd(base + 2, ack, d);
    chk("R6 new byte stored", {16'h0, d}, 32'h003C);

    // R3 miss write changes nothing
    bus_wr(base ^ 18'o002000 | 18'd6, 16'h0055, ack);
    chk("R3 miss write ack", {31'h0, ack}, 0);
    chk("R3 miss write no tx", {31'h0, tx_valid}, 0);

    // R7 transmit handshake
    bus_wr(base + 6, 16'h01A5, ack);
    chk("R7 tx_valid", {31'h0, tx_valid}, 1);
    chk("R7 tx_byte", {24'h0, tx_byte}, 32'hA5);
    bus_rd(base + 4, ack, d);
    chk("R7 ready cleared", {16'h0, d}, 32'h0000);
    bus_wr(base + 6, 16'h0033, ack);
    chk("R7 busy write ignored", {24'h0, tx_byte}, 32'hA5);
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
    chk("R7 tx_valid drops", {31'h0, tx_valid}, 0);
    bus_rd(base + 4, ack, d);
    chk("R7 ready set", {16'h0, d}, 32'h0080);

    // R8 R9 R10 interrupts
    pulse_rx(8'h11);
    bus_wr(base, 16'h0040, ack);
    bus_wr(base + 4, 16'h0040, ack);
    chk("R8 both requests", {30'h0, irq_rx, irq_tx}, 32'h3);
    chk("R10 rx vector held", {22'h0, vec_valid, vec}, {22'h0, 1'b1, exp_vec(vec_strap, 0)});
    chk("R9 rx vector value", {23'h0, vec}, 32'o300);
    pulse_ack();
    chk("R10 released", {31'h0, vec_valid}, 0);
    @(negedge clk);
    chk("R10 rx preferred", {22'h0, vec_valid, vec}, {22'h0, 1'b1, exp_vec(vec_strap, 0)});
    bus_rd(base + 2, ack, d);
    chk("R8 rx request cleared", {31'h0, irq_rx}, 0);
    chk("R10 vector stable", {22'h0, vec_valid, vec}, {22'h0, 1'b1, exp_vec(vec_strap, 0)});
    pulse_ack();
    @(negedge clk);
    chk("R9 tx vector base+4", {22'h0, vec_valid, vec}, {22'h0, 1'b1, exp_vec(vec_strap, 1)});
    bus_wr(base + 4, 16'h0000, ack);
    chk("R8 tx request off", {31'h0, irq_tx}, 0);
    pulse_ack();
    @(negedge clk);
    chk("R10 idle after ack", {22'h0, vec_valid, vec}, 32'h0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule